// File: doc/BRIEF.md
# Compact 64-bit Integer Execution Unit

This block executes the arithmetic, logic, shift, compare and bit-count instructions of a 16-bit compressed instruction set whose register file holds eight 64-bit registers. Decode hands it the 5-bit opcode, the 3-bit field that serves as a function selector or a short shift amount, the 6-bit immediate, and the values of the two source registers. Each cycle the unit registers a 64-bit result, a register-file write enable and an illegal-instruction flag. Loads, stores and control transfers are handled elsewhere. Those opcodes pass through with no write and no flag.

The first operand `src_x` is the register named by the destination field for add-immediate, compare and the unary group. For the three-register and immediate-shift forms it is `rb`. The second operand `src_y` is `ra` for three-register forms and `rb` for compare. Every output appears one clock after its inputs.

Top module: `cexu`

## Requirements
- R1: While `rst_n` is low, and at the first clock edge after reset is applied, `result`, `wr_en` and `illegal` are all 0.
- R2: Opcodes 10101 (and), 10110 (or), 10111 (xor), 11000 (sub, x minus y) and 11100 (add) produce `x op y`, with add and sub wrapping modulo 2^64.
- R3: Opcodes 11001 (logical right), 11010 (arithmetic right) and 11011 (left) shift `src_x` by the low 6 bits of `src_y`. The upper bits of `src_y` are ignored.
- R4: Opcodes 01001 (logical right), 01010 (arithmetic right) and 01011 (left) shift `src_x` by the unsigned 3-bit field `fn3`, so the amount is 0 to 7.
- R5: Opcode 01100 yields `src_x` plus the sign-extended `imm6`. Opcode 01000 yields the sign-extended `imm6` and ignores `src_x`.
- R6: Opcode 10000 compares `src_x` with `src_y` and yields 1 or 0. The `fn3` codes are: 0 signed less-than, 1 signed greater-or-equal, 2 equal, 3 not-equal, 4 unsigned less-than, 5 unsigned greater-or-equal.
- R7: Opcode 10001 applies a unary function to `src_x`. The `fn3` codes are: 0 bitwise not, 1 two's-complement negate, 2 count trailing zeros, 3 count leading zeros, 4 population count. Both counts give 64 for a zero operand.
- R8: Opcode 11111, compare with `fn3` 6 or 7, and unary with `fn3` 5 to 7 set `illegal` to 1, with `wr_en` 0 and `result` 0.
- R9: Every other opcode (00000 to 00111, 01101 to 01111, 10010 to 10100, 11101, 11110) gives `wr_en` 0, `illegal` 0 and `result` 0.
- R10: `wr_en` is 1, and `illegal` is 0, exactly one cycle after every operation covered by R2 to R7. `wr_en` and `illegal` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | 5 | Instruction opcode |
| fn3 | input | 3 | Function selector or immediate shift amount |
| imm6 | input | 6 | Signed immediate |
| src_x | input | 64 | First operand |
| src_y | input | 64 | Second operand |
| result | output | 64 | Registered result |
| wr_en | output | 1 | Register-file write enable |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
The assertions assume that every input is a known value at each sampled edge while out of reset, and that an instruction is present on every cycle, with no valid qualifier. The bench always drives defined values on each falling edge. It sweeps all 32 opcodes against all eight `fn3` codes with chosen operand patterns, then adds pseudo-random vectors. Operand patterns include zero, all ones, the signed extremes and shift counts with high bits set in `src_y`.

// File: rtl/cexu.sv
module cexu #(
  parameter int XLEN = 64,
  parameter int OPW  = 5,
  parameter int FNW  = 3,
  parameter int IMMW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OPW-1:0]  opcode,
  input  logic [FNW-1:0]  fn3,
  input  logic [IMMW-1:0] imm6,
  input  logic [XLEN-1:0] src_x,
  input  logic [XLEN-1:0] src_y,
  output logic [XLEN-1:0] result,
  output logic            wr_en,
  output logic            illegal
);
  localparam int SHW = $clog2(XLEN);
  localparam int CW  = SHW + 1;

  function automatic logic [CW-1:0] f_ctz(input logic [XLEN-1:0] v);
    logic [CW-1:0] c = CW'(XLEN);
    for (int i = XLEN - 1; i >= 0; i--) if (v[i]) c = CW'(i);
    return c;
  endfunction

  function automatic logic [CW-1:0] f_clz(input logic [XLEN-1:0] v);
    logic [CW-1:0] c = CW'(XLEN);
    for (int i = 0; i < XLEN; i++) if (v[i]) c = CW'(XLEN - 1 - i);
    return c;
  endfunction

  function automatic logic [CW-1:0] f_pop(input logic [XLEN-1:0] v);
    logic [CW-1:0] c = '0;
    for (int i = 0; i < XLEN; i++) c = c + CW'(v[i]);
    return c;
  endfunction

  wire [XLEN-1:0] simm  = {{(XLEN-IMMW){imm6[IMMW-1]}}, imm6};
  wire [SHW-1:0]  ramt  = src_y[SHW-1:0];
  wire            s_lt  = $signed(src_x) < $signed(src_y);
  wire            u_lt  = src_x < src_y;
  wire            eq    = src_x == src_y;

  logic [XLEN-1:0] n_res;
  logic            n_we, n_ill;

  always_comb begin
    n_res = '0;
    n_we  = 1'b0;
    n_ill = 1'b0;
    case (opcode)
      5'b10101: begin n_res = src_x & src_y; n_we = 1'b1; end
      5'b10110: begin n_res = src_x | src_y; n_we = 1'b1; end
      5'b10111: begin n_res = src_x ^ src_y; n_we = 1'b1; end
      5'b11000: begin n_res = src_x - src_y; n_we = 1'b1; end
      5'b11100: begin n_res = src_x + src_y; n_we = 1'b1; end
      5'b11001: begin n_res = src_x >> ramt; n_we = 1'b1; end
      5'b11010: begin n_res = $unsigned($signed(src_x) >>> ramt); n_we = 1'b1; end
      5'b11011: begin n_res = src_x << ramt; n_we = 1'b1; end
      5'b01001: begin n_res = src_x >> fn3; n_we = 1'b1; end
      5'b01010: begin n_res = $unsigned($signed(src_x) >>> fn3); n_we = 1'b1; end
      5'b01011: begin n_res = src_x << fn3; n_we = 1'b1; end
      5'b01100: begin n_res = src_x + simm; n_we = 1'b1; end
      5'b01000: begin n_res = simm; n_we = 1'b1; end
      5'b10000: begin
        n_we = 1'b1;
        case (fn3)
          3'd0: n_res = XLEN'(s_lt);
          3'd1: n_res = XLEN'(!s_lt);
          3'd2: n_res = XLEN'(eq);
          3'd3: n_res = XLEN'(!eq);
          3'd4: n_res = XLEN'(u_lt);
          3'd5: n_res = XLEN'(!u_lt);
          default: begin n_we = 1'b0; n_ill = 1'b1; end
        endcase
      end
      5'b10001: begin
        n_we = 1'b1;
        case (fn3)
          3'd0: n_res = ~src_x;
          3'd1: n_res = '0 - src_x;
          3'd2: n_res = XLEN'(f_ctz(src_x));
          3'd3: n_res = XLEN'(f_clz(src_x));
          3'd4: n_res = XLEN'(f_pop(src_x));
          default: begin n_we = 1'b0; n_ill = 1'b1; end
        endcase
      end
      5'b11111: n_ill = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      wr_en   <= 1'b0;
      illegal <= 1'b0;
    end else begin
      result  <= n_res;
      wr_en   <= n_we;
      illegal <= n_ill;
    end
  end
endmodule

module cexu_chk #(
  parameter int XLEN = 64,
  parameter int OPW  = 5,
  parameter int FNW  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [OPW-1:0]  opcode,
  input logic [FNW-1:0]  fn3,
  input logic [XLEN-1:0] src_x,
  input logic [XLEN-1:0] result,
  input logic            wr_en,
  input logic            illegal
);
  // R10
  we_ill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && illegal));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> result == '0);

  // R6
  cmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 5'b10000 && fn3 < 3'd6) |=> (wr_en && result[XLEN-1:1] == '0));

  // R7
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 5'b10001 && fn3 == 3'd4) |=> result == XLEN'($countones($past(src_x))));

  // R8
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 5'b11111) |=> (illegal && !wr_en));

  // R5
  li_ignores_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 5'b01000) |=> (wr_en && (result[XLEN-1:5] == '0 || result[XLEN-1:5] == '1)));
endmodule

bind cexu cexu_chk #(.XLEN(XLEN), .OPW(OPW), .FNW(FNW)) u_chk (
  .clk(clk), .rst_n(rst_n), .opcode(opcode), .fn3(fn3), .src_x(src_x),
  .result(result), .wr_en(wr_en), .illegal(illegal)
);

// File: tb/cexu_test.sv
module cexu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  opcode = '0;
  logic [2:0]  fn3 = '0;
  logic [5:0]  imm6 = '0;
  logic [63:0] src_x = '0, src_y = '0;
  logic [63:0] result;
  logic        wr_en, illegal;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cexu uut (.clk(clk), .rst_n(rst_n), .opcode(opcode), .fn3(fn3), .imm6(imm6),
            .src_x(src_x), .src_y(src_y), .result(result), .wr_en(wr_en),
            .illegal(illegal));

  task automatic check(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s op=%b fn=%0d act=%h exp=%h", tag, what, opcode, fn3, act, exp);
    end
  endtask

  task automatic model(input logic [4:0] op, input logic [2:0] f, input logic [5:0] im,
                       input logic [63:0] x, input logic [63:0] y,
                       output logic [63:0] r, output logic we, output logic il,
                       output string tag);
    longint sx = $signed(x), sy = $signed(y), si = $signed(im);
    int n;
    r = 0; we = 1; il = 0; tag = "R9";
    case (op)
      5'b10101: begin r = x & y; tag = "R2"; end
      5'b10110: begin r = x | y; tag = "R2"; end
      5'b10111: begin r = x ^ y; tag = "R2"; end
      5'b11000: begin r = x - y; tag = "R2"; end
      5'b11100: begin r = x + y; tag = "R2"; end
      5'b11001: begin r = x >> (y % 64); tag = "R3"; end
      5'b11010: begin r = sx >>> (y % 64); tag = "R3"; end
      5'b11011: begin r = x << (y % 64); tag = "R3"; end
      5'b01001: begin r = x >> f; tag = "R4"; end
      5'b01010: begin r = sx >>> f; tag = "R4"; end
      5'b01011: begin r = x << f; tag = "R4"; end
      5'b01100: begin r = sx + si; tag = "R5"; end
      5'b01000: begin r = si; tag = "R5"; end
      5'b10000: begin
        tag = "R6";
        if (f == 0) r = (sx < sy);
        else if (f == 1) r = (sx >= sy);
        else if (f == 2) r = (x == y);
        else if (f == 3) r = (x != y);
        else if (f == 4) r = (x < y);
        else if (f == 5) r = (x >= y);
        else begin we = 0; il = 1; tag = "R8"; end
      end
      5'b10001: begin
        tag = "R7";
        if (f == 0) r = ~x;
        else if (f == 1) r = -sx;
        else if (f == 2) begin n = 0; while (n < 64 && !x[n]) n++; r = n; end
        else if (f == 3) begin n = 0; while (n < 64 && !x[63-n]) n++; r = n; end
        else if (f == 4) begin n = 0; for (int k = 0; k < 64; k++) n += x[k]; r = n; end
        else begin we = 0; il = 1; tag = "R8"; end
      end
      5'b11111: begin we = 0; il = 1; tag = "R8"; end
      default: we = 0;
    endcase
  endtask

  task automatic apply(input logic [4:0] op, input logic [2:0] f, input logic [5:0] im,
                       input logic [63:0] x, input logic [63:0] y);
    logic [63:0] er; logic ew, ei; string tag;
    @(negedge clk);
    opcode = op; fn3 = f; imm6 = im; src_x = x; src_y = y;
    model(op, f, im, x, y, er, ew, ei, tag);
    @(posedge clk); #1;
    check(tag, "result", result, er);
    check(ew ? "R10" : tag, "wr_en", 64'(wr_en), 64'(ew));
    check(ei ? "R8" : "R10", "illegal", 64'(illegal), 64'(ei));
  endtask

  function automatic logic [63:0] pat(input int p, input bit second);
    case (p)
      0: return 64'h0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return second ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h8000_0000_0000_0000;
      3: return second ? 64'hFFFF_FF00_0000_007F : 64'h0000_0100_0000_0000;
      4: return second ? 64'h0123_4567_89AB_CDEF : 64'h0123_4567_89AB_CDEF;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    opcode = 5'b11100; src_x = 64'd5; src_y = 64'd7;
    repeat (2) @(posedge clk);
    #1;
    check("R1", "result", result, 64'h0);
    check("R1", "wr_en", 64'(wr_en), 64'h0);
    check("R1", "illegal", 64'(illegal), 64'h0);
    @(negedge clk); rst_n = 1'b1;
    for (int op = 0; op < 32; op++)
      for (int f = 0; f < 8; f++)
        for (int p = 0; p < 7; p++)
          apply(5'(op), 3'(f), 6'(p * 9 + f), pat(p, 0), pat(p, 1));
    apply(5'b11010, 3'd0, 6'd0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FF3F);
    apply(5'b11011, 3'd0, 6'd0, 64'h1, 64'h40);
    apply(5'b01100, 3'd0, 6'b100000, 64'h0, 64'h0);
    apply(5'b01000, 3'd0, 6'b011111, 64'hDEAD, 64'h0);
    apply(5'b10001, 3'd2, 6'd0, 64'h0, 64'h0);
    apply(5'b10001, 3'd3, 6'd0, 64'h0, 64'h0);
    for (int i = 0; i < 3000; i++)
      apply(5'($urandom), 3'($urandom), 6'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
    @(negedge clk); rst_n = 1'b0; opcode = 5'b11111;
    @(posedge clk); #1;
    check("R1", "illegal", 64'(illegal), 64'h0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule